// File: doc/BRIEF.md
# Audio Master-Clock Ratio Classifier with De-Emphasis Control

This block sits beside the serial input of an audio converter and works out how the master clock relates to the frame (word-select) clock. It counts master-clock cycles from one rising frame edge to the next. When two back-to-back counts agree and hit one of the supported ratios, it reports a ratio class and raises a valid flag.

From the class it builds an internal bit clock by dividing the master clock. The bit clock is given as a one-cycle strobe in the master-clock domain, and the strobe phase is reset at every frame edge. The bit-clock rate follows the frame layout:
- 72 bits per frame at the ratio 1152.
- 48 bits per frame at 96, 192, 384 and 768.
- 64 bits per frame (24-bit words) or 32 bits per frame (16-bit words) at 64, 128, 256, 512 and 1024.

The same external pin serves two purposes. In external bit-clock mode it carries the bit clock, and this block ignores it. In internal mode it is a level control for the de-emphasis filter. The pin is sampled on each falling frame edge. The de-emphasis output changes only after five samples in a row share one level: low turns de-emphasis on, high turns it off. The frame input and the pin each pass through a two-flop synchroniser before use.

Top module: `audio_clk_ratio_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, `ratio_valid_o`, `bit_strobe_o` and `deemph_o` are 0 and `ratio_class_o` is 0.
- R2: `ratio_class_o` encodes the accepted ratio as follows: 0 none, 1 = 64, 2 = 96, 3 = 128, 4 = 192, 5 = 256, 6 = 384, 7 = 512, 8 = 768, 9 = 1024, 10 = 1152. It is 0 whenever `ratio_valid_o` is 0.
- R3: A ratio is accepted only at the third rising frame edge of a run of constant frame length, that is, after two equal consecutive measurements. `ratio_valid_o` rises three master-clock cycles after that edge reaches `frame_i`.
- R4: `ratio_valid_o` drops when a measured frame length is not one of the supported ratios. It also drops when the length differs from the one before. It also drops when 1153 master-clock cycles pass with no rising frame edge.
- R5: While valid in internal mode, `bit_strobe_o` pulses once every ratio/bits-per-frame master-clock cycles. Bits per frame are 72 for 1152, 48 for the 96-family, and 64 (with `word16_i`=0) or 32 (with `word16_i`=1) for the 64-family. A divider of 1 keeps the strobe high.
- R6: Each rising or falling frame edge resets the strobe phase: a strobe occurs exactly three master-clock cycles after the edge reaches `frame_i`.
- R7: `bit_strobe_o` stays 0 while `ratio_valid_o` is 0 or `ext_mode_i` is 1.
- R8: In internal mode, `deemph_o` becomes 1 after the pin is sampled low on five consecutive falling frame edges, and 0 after five consecutive high samples.
- R9: A sample that differs from the current run restarts the count at one, and `deemph_o` keeps its value until a full run of five completes.
- R10: With `ext_mode_i`=1, `deemph_o` is forced to 0, the run count is cleared and the pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low reset, synchronous to `clk_i` |
| frame_i | input | 1 | Frame (word-select) clock, asynchronous |
| shared_pin_i | input | 1 | Shared de-emphasis level / external bit clock pin, asynchronous |
| ext_mode_i | input | 1 | 1 = bit clock supplied externally on the shared pin |
| word16_i | input | 1 | 1 = 16-bit frame layout (32 bits per frame in the 64-family) |
| ratio_class_o | output | 4 | Accepted ratio class, encoded per R2 |
| ratio_valid_o | output | 1 | Ratio class is locked |
| bit_strobe_o | output | 1 | One-cycle internal bit-clock strobe |
| deemph_o | output | 1 | De-emphasis enable |

## Verification
A corrupted period counter or a wrong previous-measurement register shows at the ports as a valid flag that never rises, or one that rises on the second frame instead of the third. It also shows as a valid flag that stays up through a frame of unsupported length. Each of these is visible within one frame of the fault.

A wrong divider selection changes the spacing between strobes at once. A missing realignment shows at the first falling frame edge that is moved against the strobe grid.

A de-emphasis run counter that is off by one moves the output change by exactly one frame. A run counter that does not restart on a mismatch lets a broken run switch the output.

// File: rtl/acr_pkg.sv
package acr_pkg;

   typedef enum logic [3:0] {
      RC_NONE = 4'd0,
      RC_64   = 4'd1,
      RC_96   = 4'd2,
      RC_128  = 4'd3,
      RC_192  = 4'd4,
      RC_256  = 4'd5,
      RC_384  = 4'd6,
      RC_512  = 4'd7,
      RC_768  = 4'd8,
      RC_1024 = 4'd9,
      RC_1152 = 4'd10
   } ratio_e;

   // Map a measured frame length in master-clock cycles to a class.
   function automatic ratio_e classify(input logic [15:0] n);
      ratio_e r;
      case (n)
         16'd64:   r = RC_64;
         16'd96:   r = RC_96;
         16'd128:  r = RC_128;
         16'd192:  r = RC_192;
         16'd256:  r = RC_256;
         16'd384:  r = RC_384;
         16'd512:  r = RC_512;
         16'd768:  r = RC_768;
         16'd1024: r = RC_1024;
         16'd1152: r = RC_1152;
         default:  r = RC_NONE;
      endcase
      return r;
   endfunction

   // log2 of the master-clock to bit-clock divider for a class.
   function automatic logic [2:0] div_log2(input ratio_e rc, input logic w16);
      logic [2:0] l;
      case (rc)
         RC_64:   l = 3'd0 + {2'b00, w16};
         RC_128:  l = 3'd1 + {2'b00, w16};
         RC_256:  l = 3'd2 + {2'b00, w16};
         RC_512:  l = 3'd3 + {2'b00, w16};
         RC_1024: l = 3'd4 + {2'b00, w16};
         RC_96:   l = 3'd1;
         RC_192:  l = 3'd2;
         RC_384:  l = 3'd3;
         RC_768:  l = 3'd4;
         RC_1152: l = 3'd4;
         default: l = 3'd0;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/acr_sync.sv
module acr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("acr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (!rst_ni) chain_q[0] <= 1'b0;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk_i) begin
            if (!rst_ni) chain_q[i] <= 1'b0;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/acr_ratio_meter.sv
module acr_ratio_meter
   import acr_pkg::*;
#(
   parameter int MAX_RATIO = 1152
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   rise_i,
   output ratio_e class_o,
   output logic   valid_o
);
   localparam int CW = $clog2(MAX_RATIO + 2);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_RATIO + 1);

   if (CW > 16) begin : g_bad_width
      $error("acr_ratio_meter: MAX_RATIO too large for classifier");
   end
   if (MAX_RATIO < 1152) begin : g_bad_max
      $error("acr_ratio_meter: MAX_RATIO must cover the largest ratio");
   end

   logic [CW-1:0] cnt_q;
   logic          armed_q;
   logic          vld_q;
   ratio_e        prev_q;
   ratio_e        cls_q;
   ratio_e        cur;

   assign cur = classify(16'(cnt_q));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         vld_q   <= 1'b0;
         prev_q  <= RC_NONE;
         cls_q   <= RC_NONE;
      end else if (rise_i) begin
         cnt_q   <= CW'(1);
         armed_q <= 1'b1;
         if (armed_q) begin
            prev_q <= cur;
            if (cur != RC_NONE && cur == prev_q) begin
               vld_q <= 1'b1;
               cls_q <= cur;
            end else begin
               vld_q <= 1'b0;
               cls_q <= RC_NONE;
            end
         end
      end else if (cnt_q == LIMIT) begin
         armed_q <= 1'b0;
         prev_q  <= RC_NONE;
         vld_q   <= 1'b0;
         cls_q   <= RC_NONE;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign class_o = cls_q;
   assign valid_o = vld_q;

   // R3: lock is only ever gained at a rising frame edge
   p_lock_on_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(vld_q) |-> $past(rise_i));

   // R4: the period counter never runs past the timeout limit
   p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIMIT);

   // R4: with no edge at the limit, the lock is lost next cycle
   p_timeout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == LIMIT && !rise_i) |=> !vld_q);

   // R2: class only changes at a rising edge or at timeout
   p_class_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cls_q) |-> ($past(rise_i) || $past(cnt_q == LIMIT)));
endmodule

// File: rtl/acr_strobe_gen.sv
module acr_strobe_gen #(
   parameter int PH_W = 5
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       edge_i,
   input  logic       enable_i,
   input  logic [2:0] lg_i,
   output logic       strobe_o
);
   if (PH_W < 5 || PH_W > 8) begin : g_bad_phw
      $error("acr_strobe_gen: PH_W must lie in 5..8");
   end

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] mask;

   assign mask = (PH_W'(1) << lg_i) - PH_W'(1);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     ph_q <= '0;
      else if (edge_i) ph_q <= '0;
      else             ph_q <= (ph_q + PH_W'(1)) & mask;
   end

   assign strobe_o = enable_i && (ph_q == '0);

   // R6: a frame edge is followed by a strobe whenever still enabled
   p_realign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_i |=> (strobe_o || !enable_i));

   // R5: back-to-back strobes without an edge only for a divider of one
   p_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_o && $past(strobe_o) && !$past(edge_i)) |-> ($past(lg_i) == 3'd0));
endmodule

// File: rtl/acr_deemph_filter.sv
module acr_deemph_filter #(
   parameter int RUN_LEN = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fall_i,
   input  logic pin_i,
   input  logic hold_off_i,
   output logic dem_o
);
   localparam int RW = $clog2(RUN_LEN + 1);
   localparam logic [RW-1:0] FULL = RW'(RUN_LEN);

   if (RUN_LEN < 1) begin : g_bad_run
      $error("acr_deemph_filter: RUN_LEN must be at least 1");
   end

   logic [RW-1:0] run_q;
   logic [RW-1:0] run_nx;
   logic          lvl_q;
   logic          dem_q;

   always_comb begin
      if (run_q == '0 || pin_i != lvl_q) run_nx = RW'(1);
      else if (run_q == FULL)            run_nx = FULL;
      else                               run_nx = run_q + RW'(1);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q <= '0;
         lvl_q <= 1'b1;
         dem_q <= 1'b0;
      end else if (hold_off_i) begin
         run_q <= '0;
         lvl_q <= 1'b1;
         dem_q <= 1'b0;
      end else if (fall_i) begin
         run_q <= run_nx;
         lvl_q <= pin_i;
         if (run_nx == FULL) dem_q <= ~pin_i;
      end
   end

   assign dem_o = dem_q;

   // R9: the run count never exceeds its full length
   p_run_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= FULL);

   // R8: the output moves only after a falling frame edge or a mode change
   p_dem_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(dem_q) |-> ($past(fall_i) || $past(hold_off_i)));

   // R10: external mode clears the enable
   p_ext_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_off_i |=> !dem_q);
endmodule

// File: rtl/audio_clk_ratio_ctl.sv
module audio_clk_ratio_ctl
   import acr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_RATIO   = 1152,
   parameter int RUN_LEN     = 5,
   parameter int PH_W        = 5
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       frame_i,
   input  logic       shared_pin_i,
   input  logic       ext_mode_i,
   input  logic       word16_i,
   output logic [3:0] ratio_class_o,
   output logic       ratio_valid_o,
   output logic       bit_strobe_o,
   output logic       deemph_o
);
   logic   frame_s;
   logic   frame_d_q;
   logic   pin_s;
   logic   rise_p;
   logic   fall_p;
   ratio_e cls;
   logic   vld;
   logic   enable;
   logic [2:0] lg;

   acr_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (frame_i), .q_o (frame_s));

   acr_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (shared_pin_i), .q_o (pin_s));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) frame_d_q <= 1'b0;
      else         frame_d_q <= frame_s;
   end

   assign rise_p = frame_s & ~frame_d_q;
   assign fall_p = ~frame_s & frame_d_q;

   acr_ratio_meter #(.MAX_RATIO(MAX_RATIO)) u_meter (
      .clk_i (clk_i), .rst_ni (rst_ni), .rise_i (rise_p),
      .class_o (cls), .valid_o (vld));

   assign enable = vld & ~ext_mode_i;
   assign lg     = div_log2(cls, word16_i);

   acr_strobe_gen #(.PH_W(PH_W)) u_strobe (
      .clk_i (clk_i), .rst_ni (rst_ni), .edge_i (rise_p | fall_p),
      .enable_i (enable), .lg_i (lg), .strobe_o (bit_strobe_o));

   acr_deemph_filter #(.RUN_LEN(RUN_LEN)) u_deemph (
      .clk_i (clk_i), .rst_ni (rst_ni), .fall_i (fall_p), .pin_i (pin_s),
      .hold_off_i (ext_mode_i), .dem_o (deemph_o));

   assign ratio_class_o = cls;
   assign ratio_valid_o = vld;

   // R2: a locked ratio always carries a real class, an unlocked one none
   p_class_matches_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ratio_valid_o == (ratio_class_o != 4'd0));

   // R7: no strobe while unlocked
   p_no_strobe_unlocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ratio_valid_o |-> !bit_strobe_o);
endmodule

// File: tb/sim_audio_clk_ratio_ctl.sv
module sim_audio_clk_ratio_ctl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame = 1'b0;
   logic       pin = 1'b1;
   logic       ext = 1'b0;
   logic       w16 = 1'b0;
   logic [3:0] cls;
   logic       vld;
   logic       stb;
   logic       dem;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rise_cnt = 0;
   int fall_cnt = 0;
   int fall_cyc = 0;
   int hi_len = 128;
   int lo_len = 128;
   bit gen_on = 1'b0;

   audio_clk_ratio_ctl u0 (
      .clk_i (clk), .rst_ni (rst_n), .frame_i (frame), .shared_pin_i (pin),
      .ext_mode_i (ext), .word16_i (w16), .ratio_class_o (cls),
      .ratio_valid_o (vld), .bit_strobe_o (stb), .deemph_o (dem));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // frame generator, drives at falling clock edges
   initial begin
      forever begin
         if (gen_on) begin
            frame = 1'b1;
            rise_cnt++;
            repeat (hi_len) @(negedge clk);
            frame = 1'b0;
            fall_cnt++;
            fall_cyc = cyc;
            repeat (lo_len) @(negedge clk);
         end else begin
            @(negedge clk);
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      @(posedge clk);
      while (cyc < 190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d, expected completion earlier", cyc);
      finish_run();
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rises(int n);
      int target = rise_cnt + n;
      while (rise_cnt < target) @(negedge clk);
   endtask

   task automatic wait_falls(int n);
      int target = fall_cnt + n;
      while (fall_cnt < target) @(negedge clk);
   endtask

   task automatic set_ratio(int r);
      hi_len = r / 2;
      lo_len = r - r / 2;
   endtask

   function automatic int ratio_of(int idx);
      case (idx)
         0: return 64;   1: return 96;   2: return 128;  3: return 192;
         4: return 256;  5: return 384;  6: return 512;  7: return 768;
         8: return 1024; default: return 1152;
      endcase
   endfunction

   function automatic int exp_class(int r);
      case (r)
         64: return 1;   96: return 2;   128: return 3;  192: return 4;
         256: return 5;  384: return 6;  512: return 7;  768: return 8;
         1024: return 9; 1152: return 10; default: return 0;
      endcase
   endfunction

   function automatic int exp_div(int r, bit w);
      if (r == 1152) return 16;
      if (r == 96 || r == 192 || r == 384 || r == 768) return r / 48;
      return w ? r / 32 : r / 64;
   endfunction

   // spacing between two consecutive strobes, 0 if none seen
   task automatic strobe_gap(output int gap);
      int guard = 0;
      gap = 0;
      while (stb !== 1'b1 && guard < 200) begin tick(1); guard++; end
      if (stb !== 1'b1) return;
      tick(1);
      gap = 1;
      while (stb !== 1'b1 && gap < 200) begin tick(1); gap++; end
   endtask

   task automatic pin_frames(bit v, int n);
      for (int i = 0; i < n; i++) begin
         wait_rises(1);
         pin = v;
      end
      wait_falls(1);
      tick(4);
   endtask

   initial begin
      int gap;
      int hi_seen;
      void'($urandom(32'd4417));

      // R1: reset state
      tick(5);
      chk("R1 valid in reset", vld, 0);
      chk("R1 strobe in reset", stb, 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 valid after reset", vld, 0);
      chk("R1 class after reset", cls, 0);
      chk("R1 deemph after reset", dem, 0);

      // R3: lock needs the third rising edge
      set_ratio(256);
      gen_on = 1'b1;
      wait_rises(2);
      tick(10);
      chk("R3 no lock after two edges", vld, 0);
      wait_rises(1);
      tick(4);
      chk("R3 lock after third edge", vld, 1);
      chk("R2 class for 256", cls, 5);
      strobe_gap(gap);
      chk("R5 divider for 256/64", gap, 4);

      // R6: shift the falling edge against the strobe grid
      hi_len = 515;
      lo_len = 509;
      wait_rises(5);
      tick(4);
      chk("R2 class for 1024", cls, 9);
      begin
         int f0 = fall_cnt;
         while (fall_cnt == f0) tick(1);
         while (cyc != fall_cyc + 2) tick(1);
         chk("R6 no strobe before realign", stb, 0);
         tick(1);
         chk("R6 strobe three cycles after fall", stb, 1);
         tick(16);
         chk("R5 strobe one divider after realign", stb, 1);
      end

      // R2/R5: random supported ratios and word sizes
      for (int t = 0; t < 6; t++) begin
         int r = ratio_of(int'($urandom % 10));
         w16 = 1'($urandom % 2);
         set_ratio(r);
         wait_rises(5);
         tick(4);
         chk($sformatf("R3 valid at ratio %0d", r), vld, 1);
         chk($sformatf("R2 class at ratio %0d", r), cls, exp_class(r));
         strobe_gap(gap);
         chk($sformatf("R5 divider at ratio %0d w16 %0d", r, w16), gap, exp_div(r, w16));
      end
      w16 = 1'b0;

      // R4/R7: unsupported frame length
      set_ratio(200);
      wait_rises(4);
      tick(4);
      chk("R4 unsupported drops lock", vld, 0);
      chk("R2 class none when unlocked", cls, 0);
      hi_seen = 0;
      for (int i = 0; i < 60; i++) begin tick(1); if (stb) hi_seen++; end
      chk("R7 no strobe while unlocked", hi_seen, 0);

      // R4: missing frame edges
      set_ratio(128);
      wait_rises(5);
      tick(4);
      chk("R2 class for 128", cls, 3);
      gen_on = 1'b0;
      tick(1400);
      chk("R4 timeout drops lock", vld, 0);

      // R7: external mode stops the strobe
      set_ratio(64);
      gen_on = 1'b1;
      wait_rises(5);
      tick(4);
      chk("R3 lock at 64", vld, 1);
      ext = 1'b1;
      tick(2);
      hi_seen = 0;
      for (int i = 0; i < 40; i++) begin tick(1); if (stb) hi_seen++; end
      chk("R7 no strobe in external mode", hi_seen, 0);

      // R8/R9: de-emphasis run filter in internal mode
      ext = 1'b0;
      pin = 1'b1;
      tick(2);
      pin_frames(1'b0, 4);
      chk("R8 four low samples keep off", dem, 0);
      pin_frames(1'b0, 1);
      chk("R8 fifth low sample turns on", dem, 1);
      pin_frames(1'b1, 3);
      pin_frames(1'b0, 1);
      pin_frames(1'b1, 4);
      chk("R9 broken high run holds on", dem, 1);
      pin_frames(1'b1, 1);
      chk("R8 five high samples turn off", dem, 0);
      pin_frames(1'b0, 5);
      chk("R8 five low samples turn on again", dem, 1);

      // R10: external mode forces off and ignores the pin
      ext = 1'b1;
      tick(4);
      chk("R10 external mode clears enable", dem, 0);
      pin_frames(1'b0, 6);
      chk("R10 pin ignored in external mode", dem, 0);
      ext = 1'b0;
      pin_frames(1'b0, 4);
      chk("R10 run restarts after external mode", dem, 0);

      gen_on = 1'b0;
      tick(4);
      finish_run();
   end
endmodule